// File: doc/BRIEF.md
# Block-wrapping EEPROM address sequencer

This block turns already-decoded two-wire bus events into addresses for a 1024-byte byte-wide array organised as four 256-byte blocks. A write command supplies two block-select bits and is followed by a word-address byte and optional data bytes. The data bytes are collected in a 16-entry page buffer and written to the array together when the stop event arrives. A read command keeps the block chosen by the most recent write command. Each read-byte acknowledge advances the offset, and the offset wraps within the current block.

A power-good input acts as a port reset. While it is low the sequencer returns to block 0, offset 0 and idle, any pending page is discarded, and every bus event is ignored. A small bank of sticky protection flags is forced to all ones during that time. Once power is good, the flags can be loaded with new values. The array is a plain register memory with no reset, so its contents survive port resets.

Top module: `eeprom_addr_seq`

## Requirements
- R1: A write command (`cmd_wr`) latches `cmd_blk` as the current block. `mem_addr` is `{block[1:0], offset[7:0]}`, with the block in bits 9:8.
- R2: A read command (`cmd_rd`) leaves the latched block unchanged whatever its `cmd_blk` bits are.
- R3: Each `rd_ack` during a read advances the offset by one modulo 256. After offset 0xFF the next address is offset 0x00 of the same block, and `rd_data` always shows the array byte at `mem_addr`.
- R4: A read command with no new word address starts at the byte one past the last byte accessed, modulo 256, inside the latched block.
- R5: A word address sets the offset. Each data byte raises `pbuf_we` in its own cycle, with `pbuf_idx` equal to the in-page position (offset bits 3:0). The position then advances modulo 16 while offset bits 7:4 stay fixed, so a 17th byte overwrites the first. During data bytes `mem_addr` shows the next buffer position.
- R6: Buffered bytes reach the array only on `stop`. The bytes go to their in-page positions in the latched block, and the last value written to each position wins.
- R7: A `stop` with no buffered data bytes, such as after a random read, leaves the array unchanged.
- R8: While `pwr_good` is low the port is held in reset: block 0, offset 0, idle, pending page discarded, and bus events ignored.
- R9: While `pwr_good` is low, `sticky_q` is all ones and `sticky_we` has no effect.
- R10: With `pwr_good` high, `sticky_we` loads `sticky_wdata` into `sticky_q` on the next edge.
- R11: After `rst_n` low: `mem_addr` = 0, `pbuf_we` = 0, and `sticky_q` all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Power good; low holds the port in reset |
| cmd_wr | input | 1 | Write command event |
| cmd_rd | input | 1 | Read command event |
| cmd_blk | input | 2 | Block-select bits of the command byte |
| addr_vld | input | 1 | Word-address byte event |
| addr_byte | input | 8 | Word address |
| data_vld | input | 1 | Data byte event (write) |
| data_byte | input | 8 | Data byte |
| rd_ack | input | 1 | Master acknowledged a read byte |
| stop | input | 1 | Stop event |
| sticky_we | input | 1 | Sticky flag load strobe |
| sticky_wdata | input | 8 | Sticky flag load value |
| mem_addr | output | 10 | Current array address |
| rd_data | output | 8 | Array byte at `mem_addr` |
| pbuf_we | output | 1 | Page buffer write strobe |
| pbuf_idx | output | 4 | Page buffer position |
| pbuf_wdata | output | 8 | Page buffer write data |
| sticky_q | output | 8 | Sticky protection flags |

## Verification
The bench reads across offset 0xFF in every block. A design that carried into the block bits there would return bytes from the neighbouring block. It also issues read commands whose block bits differ from the latched block, which catches a design that reloads the block on reads. A 17-byte page write checks that the first position receives the last value; a linear counter would instead spill into the next page. A power drop in the middle of a page checks that the pending bytes are discarded, that block 0 is restored and that the sticky flags read as ones.

// File: rtl/eas_pkg.sv
// Shared types for the EEPROM address sequencer.
// Assumes a single clock domain; no parameters here.
package eas_pkg;
    typedef enum logic [1:0] {
        MD_IDLE  = 2'd0,
        MD_WADDR = 2'd1,
        MD_WDATA = 2'd2,
        MD_READ  = 2'd3
    } mode_e;
endpackage

// File: rtl/eas_addr_ctrl.sv
// Address controller: latches the block on write commands, tracks the
// in-block offset, the page base and the in-page write position.
// Assumes at most one bus event per cycle; stop has priority.
// The port is held in reset while rst_n or pwr_good is low.
module eas_addr_ctrl
    import eas_pkg::*;
#(
    parameter int BLK_W  = 2,
    parameter int OFF_W  = 8,
    parameter int PAGE_W = 4,
    localparam int ADDR_W = BLK_W + OFF_W,
    localparam int BASE_W = OFF_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic [BLK_W-1:0]  cmd_blk,
    input  logic              addr_vld,
    input  logic [OFF_W-1:0]  addr_byte,
    input  logic              data_vld,
    input  logic              rd_ack,
    input  logic              stop,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              pbuf_we,
    output logic [PAGE_W-1:0] pbuf_idx,
    output logic              pbuf_clr,
    output logic              commit,
    output logic [ADDR_W-PAGE_W-1:0] page_addr
);
    mode_e              mode_q;
    logic [BLK_W-1:0]   blk_q;
    logic [OFF_W-1:0]   off_q;
    logic [BASE_W-1:0]  base_q;
    logic [PAGE_W-1:0]  wp_q;
    logic               live;

    assign live = rst_n && pwr_good;

    // Sequencer state: block latch, offset pointer, page position.
    always_ff @(posedge clk) begin
        if (!live) begin
            mode_q <= MD_IDLE;
            blk_q  <= '0;
            off_q  <= '0;
            base_q <= '0;
            wp_q   <= '0;
        end else if (stop) begin
            mode_q <= MD_IDLE;
        end else if (cmd_wr) begin
            blk_q  <= cmd_blk;
            mode_q <= MD_WADDR;
        end else if (cmd_rd) begin
            mode_q <= MD_READ;
        end else if (addr_vld && mode_q == MD_WADDR) begin
            off_q  <= addr_byte;
            base_q <= addr_byte[OFF_W-1:PAGE_W];
            wp_q   <= addr_byte[PAGE_W-1:0];
            mode_q <= MD_WDATA;
        end else if (data_vld && mode_q == MD_WDATA) begin
            wp_q  <= wp_q + 1'b1;
            off_q <= {base_q, wp_q} + 1'b1;
        end else if (rd_ack && mode_q == MD_READ) begin
            off_q <= off_q + 1'b1;
        end
    end

    // Output address: buffer position while writing, pointer otherwise.
    always_comb begin
        if (mode_q == MD_WDATA) mem_addr = {blk_q, base_q, wp_q};
        else                    mem_addr = {blk_q, off_q};
    end

    // Page buffer strobes and commit request.
    assign pbuf_we   = live && !stop && !cmd_wr && !cmd_rd && data_vld && mode_q == MD_WDATA;
    assign pbuf_idx  = wp_q;
    assign pbuf_clr  = !live || stop || cmd_wr;
    assign commit    = live && stop;
    assign page_addr = {blk_q, base_q};

    AST_RD_KEEPS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && cmd_rd && !cmd_wr && !stop) |=> $stable(blk_q)); // R2
    AST_WR_LATCHES_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && cmd_wr && !stop) |=> (blk_q == $past(cmd_blk))); // R1
    AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && mode_q == MD_READ && rd_ack && !stop && !cmd_wr && !cmd_rd && off_q == '1)
        |=> (off_q == '0 && $stable(blk_q))); // R3
    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pbuf_we && wp_q == '1) |=> (wp_q == '0 && $stable(base_q))); // R5
    AST_PG_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (blk_q == '0 && mode_q == MD_IDLE && mem_addr == '0)); // R8
endmodule

// File: rtl/eas_page_buf.sv
// Page buffer: one byte per in-page position plus a valid mask.
// Assumes pbuf_clr comes from the controller and covers port reset.
// Data registers are not reset; the mask alone qualifies them.
module eas_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8,
    localparam int PAGE_N = 1 << PAGE_W
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [PAGE_W-1:0]        idx,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     clr,
    output logic [PAGE_N*DATA_W-1:0] page_data,
    output logic [PAGE_N-1:0]        page_mask
);
    logic [DATA_W-1:0] byte_q [PAGE_N];

    // Byte storage: last write to a position wins.
    always_ff @(posedge clk) begin
        if (we) byte_q[idx] <= wdata;
    end

    // Valid mask: set on write, cleared on stop, new command or reset.
    always_ff @(posedge clk) begin
        if (clr)     page_mask <= '0;
        else if (we) page_mask[idx] <= 1'b1;
    end

    for (genvar g = 0; g < PAGE_N; g++) begin : g_flat
        assign page_data[g*DATA_W +: DATA_W] = byte_q[g];
    end

    AST_CLR_EMPTIES: assert property (@(posedge clk)
        clr |=> (page_mask == '0)); // R8
endmodule

// File: rtl/eas_array.sv
// Register-array model of the byte memory. A commit writes every
// masked byte of one page in a single cycle; reads are combinational.
// No reset: contents persist across port resets.
module eas_array #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int PAGE_N = 1 << PAGE_W
) (
    input  logic                       clk,
    input  logic                       commit,
    input  logic [ADDR_W-PAGE_W-1:0]   page_addr,
    input  logic [PAGE_N*DATA_W-1:0]   page_data,
    input  logic [PAGE_N-1:0]          page_mask,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Page commit: masked bytes land at their in-page positions.
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (page_mask[i]) mem[{page_addr, PAGE_W'(i)}] <= page_data[i*DATA_W +: DATA_W];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eas_sticky.sv
// Sticky protection flags: forced to ones while the port is in reset,
// loadable only once power is good.
module eas_sticky #(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              we,
    input  logic [FLAG_W-1:0] wdata,
    output logic [FLAG_W-1:0] flags
);
    // Flag register with power-good override.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) flags <= '1;
        else if (we)             flags <= wdata;
    end

    AST_STICKY_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (flags == '1)); // R9
    AST_STICKY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && we) |=> (flags == $past(wdata))); // R10
endmodule

// File: rtl/eeprom_addr_seq.sv
// Top of the EEPROM address sequencer: wires the controller, page
// buffer, array model and sticky flags. Assumes decoded bus events,
// one per cycle, synchronous to clk.
module eeprom_addr_seq #(
    parameter int BLK_W  = 2,
    parameter int OFF_W  = 8,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8,
    parameter int FLAG_W = 8,
    localparam int ADDR_W = BLK_W + OFF_W,
    localparam int PAGE_N = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic [BLK_W-1:0]  cmd_blk,
    input  logic              addr_vld,
    input  logic [OFF_W-1:0]  addr_byte,
    input  logic              data_vld,
    input  logic [DATA_W-1:0] data_byte,
    input  logic              rd_ack,
    input  logic              stop,
    input  logic              sticky_we,
    input  logic [FLAG_W-1:0] sticky_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pbuf_we,
    output logic [PAGE_W-1:0] pbuf_idx,
    output logic [DATA_W-1:0] pbuf_wdata,
    output logic [FLAG_W-1:0] sticky_q
);
    logic                       pbuf_clr;
    logic                       commit;
    logic [ADDR_W-PAGE_W-1:0]   page_addr;
    logic [PAGE_N*DATA_W-1:0]   page_data;
    logic [PAGE_N-1:0]          page_mask;

    assign pbuf_wdata = data_byte;

    eas_addr_ctrl #(.BLK_W(BLK_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_blk(cmd_blk),
        .addr_vld(addr_vld), .addr_byte(addr_byte),
        .data_vld(data_vld), .rd_ack(rd_ack), .stop(stop),
        .mem_addr(mem_addr), .pbuf_we(pbuf_we), .pbuf_idx(pbuf_idx),
        .pbuf_clr(pbuf_clr), .commit(commit), .page_addr(page_addr)
    );

    eas_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_pbuf (
        .clk(clk), .we(pbuf_we), .idx(pbuf_idx), .wdata(data_byte),
        .clr(pbuf_clr), .page_data(page_data), .page_mask(page_mask)
    );

    eas_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .commit(commit), .page_addr(page_addr),
        .page_data(page_data), .page_mask(page_mask),
        .rd_addr(mem_addr), .rd_data(rd_data)
    );

    eas_sticky #(.FLAG_W(FLAG_W)) u_sticky (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .we(sticky_we), .wdata(sticky_wdata), .flags(sticky_q)
    );
endmodule

// File: tb/eeprom_addr_seq_tb.sv
// Scoreboard bench: read tasks push expected bytes and addresses into a
// queue; a negedge monitor pops and compares them. Inputs change one
// time unit after posedge or at negedge; outputs are sampled at negedge.
module eeprom_addr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pwr_good = 1'b1;
    logic cmd_wr = 0, cmd_rd = 0, addr_vld = 0, data_vld = 0, rd_ack = 0, stop = 0, sticky_we = 0;
    logic [1:0] cmd_blk = '0;
    logic [7:0] addr_byte = '0, data_byte = '0, sticky_wdata = '0;
    logic [9:0] mem_addr;
    logic [7:0] rd_data, pbuf_wdata, sticky_q;
    logic       pbuf_we;
    logic [3:0] pbuf_idx;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] model [1024];
    logic [1:0] mblk = '0;
    logic [7:0] moff = '0;

    typedef struct { string req; logic [7:0] d; logic [9:0] a; } exp_t;
    exp_t sbq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_blk(cmd_blk),
        .addr_vld(addr_vld), .addr_byte(addr_byte),
        .data_vld(data_vld), .data_byte(data_byte),
        .rd_ack(rd_ack), .stop(stop),
        .sticky_we(sticky_we), .sticky_wdata(sticky_wdata),
        .mem_addr(mem_addr), .rd_data(rd_data),
        .pbuf_we(pbuf_we), .pbuf_idx(pbuf_idx), .pbuf_wdata(pbuf_wdata),
        .sticky_q(sticky_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare each expected read item against the ports.
    always @(negedge clk) begin : mon
        exp_t e;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            chk({e.req, " rd_data"}, 32'(rd_data), 32'(e.d));
            chk({e.req, " mem_addr"}, 32'(mem_addr), 32'(e.a));
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic ev_wr(input logic [1:0] b);
        cmd_wr = 1; cmd_blk = b; tick(); cmd_wr = 0;
    endtask
    task automatic ev_rd(input logic [1:0] b);
        cmd_rd = 1; cmd_blk = b; tick(); cmd_rd = 0;
    endtask
    task automatic ev_addr(input logic [7:0] a);
        addr_vld = 1; addr_byte = a; tick(); addr_vld = 0;
    endtask
    task automatic ev_stop();
        stop = 1; tick(); stop = 0;
    endtask

    // Read n bytes; expected values come from the bench model.
    task automatic rd_seq(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            sbq.push_back('{req, model[{mblk, moff}], {mblk, moff}});
            @(negedge clk);
            rd_ack = 1;
            tick();
            rd_ack = 0;
            moff = moff + 8'd1;
        end
    endtask

    // Page write of n bytes from start offset; commit model on stop.
    task automatic page_write(input logic [1:0] b, input logic [7:0] off, input int n,
                              input logic [7:0] seed, input bit do_stop);
        logic [7:0] pb [16];
        bit         pv [16];
        logic [3:0] idx;
        for (int i = 0; i < 16; i++) pv[i] = 0;
        ev_wr(b);
        ev_addr(off);
        idx = off[3:0];
        for (int i = 0; i < n; i++) begin
            data_vld = 1; data_byte = seed + 8'(i);
            @(negedge clk);
            chk("R5 pbuf_we", 32'(pbuf_we), 32'd1);
            chk("R5 pbuf_idx", 32'(pbuf_idx), 32'(idx));
            tick();
            data_vld = 0;
            pb[idx] = seed + 8'(i); pv[idx] = 1;
            idx = idx + 4'd1;
        end
        @(negedge clk);
        chk("R5 mem_addr during write", 32'(mem_addr), 32'({b, off[7:4], idx}));
        tick();
        if (do_stop) begin
            ev_stop();
            for (int i = 0; i < 16; i++) if (pv[i]) model[{b, off[7:4], 4'(i)}] = pb[i];
            mblk = b;
            moff = (n > 0) ? ({off[7:4], idx - 4'd1} + 8'd1) : off;
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R11 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 mem_addr", 32'(mem_addr), 0);
        chk("R11 pbuf_we", 32'(pbuf_we), 0);
        chk("R11 sticky", 32'(sticky_q), 32'hFF);
        tick(); rst_n = 1; tick();

        // R10 sticky load with power good
        sticky_we = 1; sticky_wdata = 8'h5A; tick(); sticky_we = 0;
        @(negedge clk); chk("R10 sticky load", 32'(sticky_q), 32'h5A); tick();

        // Fill both ends of every block (R1, R6)
        for (int b = 0; b < 4; b++) begin
            page_write(2'(b), 8'hF0, 16, 8'(8'h10 * b + 8'h80), 1);
            page_write(2'(b), 8'h00, 16, 8'(8'h10 * b + 8'h03), 1);
        end

        // R3/R2/R1/R7: random read across FF->00, read bits differ
        for (int b = 0; b < 4; b++) begin
            ev_wr(2'(b)); ev_addr(8'hFE);
            mblk = 2'(b); moff = 8'hFE;
            ev_rd(~2'(b));
            rd_seq(4, "R3 wrap R2 block kept");
            ev_stop();
        end
        // R7: those stops wrote nothing
        ev_wr(2'd1); ev_addr(8'hFE); mblk = 2'd1; moff = 8'hFE;
        ev_rd(2'd1); rd_seq(2, "R7 no write on bare stop"); ev_stop();

        // R4: current-address read one past last written byte
        page_write(2'd2, 8'h30, 16, 8'h40, 1);
        page_write(2'd2, 8'h35, 3, 8'hC0, 1);
        chk("R4 model pointer", 32'(moff), 32'h38);
        ev_rd(2'd0);
        rd_seq(2, "R4 current read R2");
        ev_stop();

        // R5/R6: 17-byte page write wraps and overwrites position 0
        page_write(2'd1, 8'h40, 17, 8'h20, 1);
        chk("R6 model overwrite", 32'(model[{2'd1, 8'h40}]), 32'h30);
        ev_wr(2'd1); ev_addr(8'h40); mblk = 2'd1; moff = 8'h40;
        ev_rd(2'd3);
        rd_seq(16, "R6 page overwrite");
        ev_stop();

        // R8/R9: power drop during a page write
        page_write(2'd3, 8'h0E, 2, 8'hEE, 0);
        pwr_good = 0; sticky_we = 1; sticky_wdata = 8'h00;
        ev_wr(2'd2);
        @(negedge clk);
        chk("R9 sticky forced", 32'(sticky_q), 32'hFF);
        chk("R8 mem_addr reset", 32'(mem_addr), 0);
        tick();
        pwr_good = 1; sticky_we = 0; tick();
        @(negedge clk); chk("R9 sticky after restore", 32'(sticky_q), 32'hFF); tick();
        mblk = 2'd0; moff = 8'h00;
        ev_rd(2'd1);
        rd_seq(1, "R8 block reset");
        ev_stop();
        ev_wr(2'd3); ev_addr(8'h0E); mblk = 2'd3; moff = 8'h0E;
        ev_rd(2'd0);
        rd_seq(2, "R8 pending page discarded");
        ev_stop();

        tick(); tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule